// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the entry into an interrupt or reset handler for a small 8-bit microcontroller core. It watches a reset request, a vector of pending interrupt sources and the global interrupt enable flag. When the enable flag is set and there is something to service, it captures the current word program counter and the stack pointer. It then chooses which request to service.

The captured return address goes onto the stack one byte per clock through a byte-wide data memory write port. The low byte goes first, and the stack pointer decrements after every byte. After the last byte, the block presents the handler address for one cycle. In that same cycle it asks the core to clear the global enable flag and names the single pending bit to clear. The return-address length and the vector slot size are parameters.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is accepted only in a clock edge where `gie` is 1 and the sequencer is idle. With `gie` at 0, `busy` and `mem_we` stay 0.
- R2: When `reset_req` is set, it wins over any pending source. It gives vector 0, `pc_out` 0 and `ack_mask` 0.
- R3: Without a reset request, the lowest-numbered set bit of `irq_pend` is serviced. The vector number is that bit index plus one. `ack_mask` is one-hot on that bit only, so every other pending bit is left alone.
- R4: `pc_out` is the vector number times the slot size. The slot size is 2 words when `LONG_CALL` is 1 and 1 word otherwise.
- R5: In the `PC_BYTES` cycles right after the accepting edge, `mem_we` is 1 and `mem_wdata` carries `pc_in` bits [7:0], then [15:8], then [23:16], one byte per cycle, as many bytes as `PC_BYTES`.
- R6: The first push writes to `sp_in`, and each later push writes to the address one lower, wrapping modulo 2^16. With `done`, `sp_out` equals `sp_in - PC_BYTES`.
- R7: `done` and `gie_clr` are 1 for exactly one cycle, the cycle after the last push. `pc_out` and `ack_mask` are valid in that cycle and 0 in every other cycle.
- R8: `busy` is 1 from the cycle after acceptance through the `done` cycle. Requests presented during that time are ignored.
- R9: After a synchronous active-low reset, the block is idle, even in the middle of a sequence: `busy`, `mem_we`, `done`, `gie_clr`, `pc_out` and `ack_mask` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_req | input | 1 | Request to enter the reset vector |
| irq_pend | input | NUM_SRC | Pending interrupt sources, bit i = source i |
| gie | input | 1 | Global interrupt enable flag |
| pc_in | input | 8*PC_BYTES | Current word program counter (return address) |
| sp_in | input | 16 | Current stack pointer |
| busy | output | 1 | Sequence in progress |
| mem_we | output | 1 | Data memory write strobe, one push per cycle |
| mem_addr | output | 16 | Data memory write address |
| mem_wdata | output | 8 | Data memory write byte |
| done | output | 1 | One-cycle pulse: load program counter |
| pc_out | output | 8*PC_BYTES | Handler address, valid with done |
| sp_out | output | 16 | Stack pointer after the pushes, valid with done |
| gie_clr | output | 1 | One-cycle request to clear the global enable |
| ack_mask | output | NUM_SRC | One-hot pending bit to clear, valid with done |

## Verification
Suppose the captured source, vector or return address were wrong inside the block. That would show on the ports within a few cycles: at the latest in the `done` cycle, which comes `PC_BYTES + 1` cycles after acceptance, through `pc_out`, `ack_mask` or the pushed bytes. Suppose instead the byte counter or the stack-pointer copy went astray. `mem_addr` and `mem_wdata` would then differ in the very cycle of the bad push, or `done` would come early or late. The bench holds new requests on the inputs during every sequence, so a sequencer that restarted would show up as a changed vector or as an extra write cycle.

// File: rtl/irq_entry_pkg.sv
// Shared types for the interrupt entry sequencer.
// Assumes nothing beyond a synthesizable enum encoding.
package irq_entry_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/irq_entry_pick.sv
// Chooses the request to service: a reset request gives vector 0, otherwise
// the lowest set pending bit i gives vector i+1 and a one-hot clear mask.
// Assumes VW is wide enough to hold NUM_SRC.
module irq_entry_pick #(
    parameter int NUM_SRC = 8,
    parameter int VW      = 4
) (
    input  logic               reset_req,
    input  logic [NUM_SRC-1:0] pend,
    output logic [VW-1:0]      vec,
    output logic [NUM_SRC-1:0] mask,
    output logic               any
);
    // Priority select: scan from high to low so the lowest set bit wins.
    always_comb begin
        vec  = '0;
        mask = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                vec     = VW'(i + 1);
                mask    = '0;
                mask[i] = 1'b1;
            end
        end
        if (reset_req) begin
            vec  = '0;
            mask = '0;
        end
    end

    // Something to service.
    assign any = reset_req | (|pend);
endmodule

// File: rtl/irq_entry_bytesel.sv
// Picks byte idx of the captured return address for the current push.
// Assumes idx < PC_BYTES; any larger index yields zero.
module irq_entry_bytesel #(
    parameter int PC_BYTES = 2,
    parameter int CW       = 1
) (
    input  logic [8*PC_BYTES-1:0] pc,
    input  logic [CW-1:0]         idx,
    output logic [7:0]            data
);
    logic [7:0] lane [PC_BYTES];

    genvar g;
    generate
        for (g = 0; g < PC_BYTES; g++) begin : g_lane
            assign lane[g] = pc[8*g +: 8];
        end
    endgenerate

    // Byte mux over the lanes.
    always_comb begin
        data = 8'h00;
        for (int i = 0; i < PC_BYTES; i++) begin
            if (int'(idx) == i) data = lane[i];
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Interrupt entry sequencer. When idle and gie is set it accepts a reset
// request or a pending source, pushes PC_BYTES return-address bytes low first
// at sp, sp-1, ..., then presents the handler address for one cycle together
// with the global-enable clear and the one-hot pending-bit clear.
// Assumes the core holds off fetch while busy and applies the clears on done.
module irq_entry_seq #(
    parameter int PC_BYTES  = 2,
    parameter int LONG_CALL = 1,
    parameter int NUM_SRC   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reset_req,
    input  logic [NUM_SRC-1:0]    irq_pend,
    input  logic                  gie,
    input  logic [8*PC_BYTES-1:0] pc_in,
    input  logic [15:0]           sp_in,
    output logic                  busy,
    output logic                  mem_we,
    output logic [15:0]           mem_addr,
    output logic [7:0]            mem_wdata,
    output logic                  done,
    output logic [8*PC_BYTES-1:0] pc_out,
    output logic [15:0]           sp_out,
    output logic                  gie_clr,
    output logic [NUM_SRC-1:0]    ack_mask
);
    import irq_entry_pkg::*;

    localparam int PCW  = 8 * PC_BYTES;
    localparam int CW   = (PC_BYTES > 1) ? $clog2(PC_BYTES) : 1;
    localparam int VW   = $clog2(NUM_SRC + 1);
    localparam int SLOT = (LONG_CALL != 0) ? 2 : 1;

    seq_state_t         state;
    logic [CW-1:0]      cnt;
    logic [15:0]        sp_r;
    logic [PCW-1:0]     pc_r;
    logic [VW-1:0]      vec_r;
    logic [NUM_SRC-1:0] mask_r;
    logic [VW-1:0]      pick_vec;
    logic [NUM_SRC-1:0] pick_mask;
    logic               pick_any;
    logic [7:0]         push_byte;

    irq_entry_pick #(.NUM_SRC(NUM_SRC), .VW(VW)) u_pick (
        .reset_req (reset_req),
        .pend      (irq_pend),
        .vec       (pick_vec),
        .mask      (pick_mask),
        .any       (pick_any)
    );

    irq_entry_bytesel #(.PC_BYTES(PC_BYTES), .CW(CW)) u_bytesel (
        .pc   (pc_r),
        .idx  (cnt),
        .data (push_byte)
    );

    // Sequence control: capture on accept, one push per cycle, then done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sp_r   <= '0;
            pc_r   <= '0;
            vec_r  <= '0;
            mask_r <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (gie && pick_any) begin
                        state  <= ST_PUSH;
                        cnt    <= '0;
                        sp_r   <= sp_in;
                        pc_r   <= pc_in;
                        vec_r  <= pick_vec;
                        mask_r <= pick_mask;
                    end
                end
                ST_PUSH: begin
                    sp_r <= sp_r - 16'd1;
                    cnt  <= cnt + CW'(1);
                    if (cnt == CW'(PC_BYTES - 1)) state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port drive from the current state.
    always_comb begin
        busy      = (state != ST_IDLE);
        mem_we    = (state == ST_PUSH);
        mem_addr  = sp_r;
        mem_wdata = mem_we ? push_byte : 8'h00;
        done      = (state == ST_DONE);
        gie_clr   = done;
        sp_out    = sp_r;
        pc_out    = done ? PCW'(vec_r) * PCW'(SLOT) : '0;
        ack_mask  = done ? mask_r : '0;
    end

    // R1
    no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !gie) |=> !busy);
    // R3
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_mask));
    // R6
    sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 16'd1));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_we));
    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
    localparam int PCB  = 2;
    localparam int NSRC = 8;
    localparam int SLOT = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            reset_req;
    logic [NSRC-1:0] irq_pend;
    logic            gie;
    logic [15:0]     pc_in;
    logic [15:0]     sp_in;
    logic            busy, mem_we, done, gie_clr;
    logic [15:0]     mem_addr, sp_out, pc_out;
    logic [7:0]      mem_wdata;
    logic [NSRC-1:0] ack_mask;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    irq_entry_seq #(.PC_BYTES(PCB), .LONG_CALL(1), .NUM_SRC(NSRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .irq_pend(irq_pend),
        .gie(gie), .pc_in(pc_in), .sp_in(sp_in), .busy(busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done), .pc_out(pc_out),
        .sp_out(sp_out), .gie_clr(gie_clr), .ack_mask(ack_mask)
    );

    typedef struct packed {
        logic        rr;
        logic [7:0]  pend;
        logic [15:0] pc;
        logic [15:0] sp;
        logic [3:0]  vec;
        logic [7:0]  mask;
    } row_t;

    localparam row_t TBL [6] = '{
        '{1'b1, 8'h05, 16'h1234, 16'h08FF, 4'd0, 8'h00},  // R2 reset wins
        '{1'b0, 8'h0C, 16'hABCD, 16'h0100, 4'd3, 8'h04},  // R3 bit 2
        '{1'b0, 8'h80, 16'h00FF, 16'h0001, 4'd8, 8'h80},  // R3 top source
        '{1'b0, 8'h01, 16'h5A3C, 16'h0000, 4'd1, 8'h01},  // R6 wrap
        '{1'b0, 8'hFF, 16'hFFFF, 16'hFFFF, 4'd1, 8'h01},  // R3 all pending
        '{1'b1, 8'h00, 16'h0001, 16'h1000, 4'd0, 8'h00}   // R2 reset alone
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_entry(input row_t r);
        logic [15:0] e_pc;
        e_pc = 16'(r.vec) * 16'(SLOT);
        @(negedge clk);
        reset_req = r.rr; irq_pend = r.pend; pc_in = r.pc; sp_in = r.sp; gie = 1'b1;
        for (int i = 0; i < PCB; i++) begin
            @(negedge clk);
            if (i == 0) begin
                // R8: new requests while busy must be ignored
                reset_req = ~r.rr; irq_pend = 8'h40; pc_in = 16'h0BAD; sp_in = 16'h7777;
            end
            chk(mem_we == 1'b1, "R5 mem_we", 32'(mem_we), 1);
            chk(busy == 1'b1, "R8 busy", 32'(busy), 1);
            chk(mem_addr == r.sp - 16'(i), "R6 addr", 32'(mem_addr), 32'(r.sp - 16'(i)));
            chk(mem_wdata == r.pc[8*i +: 8], "R5 data", 32'(mem_wdata), 32'(r.pc[8*i +: 8]));
            chk(done == 1'b0, "R7 early done", 32'(done), 0);
        end
        @(negedge clk);
        chk(done == 1'b1 && gie_clr == 1'b1, "R7 done", {done, gie_clr}, 3);
        chk(mem_we == 1'b0, "R5 push count", 32'(mem_we), 0);
        chk(pc_out == e_pc, "R4 pc_out", 32'(pc_out), 32'(e_pc));
        chk(ack_mask == r.mask, "R3 ack_mask", 32'(ack_mask), 32'(r.mask));
        chk(sp_out == r.sp - 16'(PCB), "R6 sp_out", 32'(sp_out), 32'(r.sp - 16'(PCB)));
        reset_req = 1'b0; irq_pend = '0;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R7 single pulse", {busy, done}, 0);
        chk(pc_out == '0 && ack_mask == '0, "R7 outputs idle", {pc_out, 8'(ack_mask)}, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reset_req = 1'b0; irq_pend = '0; gie = 1'b0;
        pc_in = '0; sp_in = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!busy && !mem_we && !done && !gie_clr, "R9 reset ctrl",
            {busy, mem_we, done, gie_clr}, 0);
        chk(pc_out == '0 && ack_mask == '0, "R9 reset data", {pc_out, 8'(ack_mask)}, 0);
        rst_n = 1'b1;

        foreach (TBL[k]) run_entry(TBL[k]);

        // R1: gie low blocks acceptance
        @(negedge clk);
        gie = 1'b0; irq_pend = 8'h01; reset_req = 1'b1; sp_in = 16'h0200; pc_in = 16'h1111;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!busy && !mem_we, "R1 gie low", {busy, mem_we}, 0);
        end
        reset_req = 1'b0; irq_pend = '0;

        // R9: reset in mid sequence
        @(negedge clk);
        gie = 1'b1; irq_pend = 8'h02; sp_in = 16'h0300; pc_in = 16'h2222;
        @(negedge clk);
        chk(mem_we == 1'b1, "R5 first push", 32'(mem_we), 1);
        irq_pend = '0; rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_we && !done, "R9 abort", {busy, mem_we, done}, 0);
        rst_n = 1'b1;

        // R3: accepted after reset, bit 5 alone
        run_entry('{1'b0, 8'h20, 16'hC0DE, 16'h00FF, 4'd6, 8'h20});

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule